// File: doc/BRIEF.md
# Dual-threshold drain request scheduler

This block decides when a bus master should be asked to empty a receive-status FIFO. It watches the FIFO's word count and compares it with two programmable limits that share one configuration word. The hard limit raises a request as soon as the count is above it, whatever the system bus is doing. The soft limit raises a request only when the bus has had no transfers for a fixed number of consecutive clocks. This lets small transfers go out while the bus is lightly loaded, and saves large ones for when the bus is busy.

A request is never raised while the count of free enqueue resources is zero. Once it is raised, the request stays high until the bus master acknowledges it. After the acknowledge, the scheduler evaluates eligibility again from the current count. The configuration word is cleared by the chip reset and kept across a soft reset. The soft reset clears only the request and the idle history.

Top module: `drain_req_sched`

## Requirements
- R1: A limit is met only when `fifo_count` is strictly greater than that limit. A count equal to the limit does not request.
- R2: When the count exceeds the hard limit and `res_count` is non-zero, `bus_req` is high after the next rising clock edge, even while `bus_busy` is high.
- R3: The bus is judged idle once `bus_busy` has been low at 4 consecutive rising edges. Any edge that sees `bus_busy` high restarts the count. With a soft-only excess, `bus_req` rises at the edge after idle is reached, which is the 5th quiet edge.
- R4: Bits [17:16] and [1:0] of the configuration word always read 0 and ignore writes, so both limits are multiples of 4.
- R5: All bits of the configuration word outside [21:16] and [5:0] read 0 and ignore writes.
- R6: While `res_count` is 0, `bus_req` does not rise, even when a limit is exceeded and the bus is idle.
- R7: The chip reset (`rst_n` low) clears the configuration word to 0 and clears `bus_req`. A one-cycle `soft_rst` clears `bus_req` and the idle count and leaves the configuration word unchanged.
- R8: Once `bus_req` is high, it stays high until an edge sees `req_ack` high, even if the count falls. At that edge it drops. From the next edge it is raised again if the current count is still eligible.
- R9: A limit of 0 is met by any non-empty FIFO.
- R10: The hard limit is written through bits [21:16] and the soft limit through bits [5:0]. A write is visible on `cfg_rdata` after the edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset, asynchronous |
| soft_rst | input | 1 | Synchronous soft reset; the configuration word is kept |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Write data for the configuration word |
| cfg_rdata | output | 32 | Registered readback of the configuration word |
| fifo_count | input | CNT_W (7) | Words currently held in the status FIFO |
| bus_busy | input | 1 | High in any cycle with a transfer on the system bus |
| res_count | input | RES_W (4) | Free enqueue resources; zero blocks requests |
| req_ack | input | 1 | Acknowledge from the bus master |
| bus_req | output | 1 | Drain request to the bus master |

## Verification
Assertions check the following on every cycle:
- The hard limit takes effect within one edge.
- The request holds until an acknowledge and drops on it.
- A busy cycle cancels idle.
- A rise of the request never follows a zero resource count, or a soft-only excess without idle.
- The readback is masked, and it stays stable without a write.

Only the bench scenarios can show the exact edge at which the soft path fires, and that one busy cycle restarts the four-edge window. They also show the strict comparison at the boundary count, that a soft reset keeps the configuration word, and the full sweep of counts against several limit pairs.

// File: rtl/drq_pkg.sv
package drq_pkg;
  localparam int unsigned WORD_W = 32;

  // strict comparison: a count equal to the limit does not qualify
  function automatic logic exceeds(input logic [WORD_W-1:0] count,
                                   input logic [WORD_W-1:0] limit);
    return count > limit;
  endfunction

  // clears the low alignment bits of a limit value
  function automatic logic [WORD_W-1:0] align_down(input logic [WORD_W-1:0] v,
                                                   input int unsigned lsbs);
    logic [WORD_W-1:0] m;
    m = {WORD_W{1'b1}} << lsbs;
    return v & m;
  endfunction

  // saturating step of the quiet-cycle counter
  function automatic logic [7:0] idle_step(input logic [7:0] cur,
                                           input logic busy,
                                           input logic [7:0] limit);
    if (busy) return 8'd0;
    if (cur >= limit) return limit;
    return cur + 8'd1;
  endfunction
endpackage

// File: rtl/drq_thr_reg.sv
module drq_thr_reg #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned THR_W    = 6,
  parameter int unsigned ALIGN    = 2,
  parameter int unsigned SOFT_LSB = 0,
  parameter int unsigned HARD_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic [THR_W-1:0]  soft_thr,
  output logic [THR_W-1:0]  hard_thr
);
  localparam int unsigned STORE_W = THR_W - ALIGN;
  localparam int unsigned NFIELD  = 2;
  localparam logic [DATA_W-1:0] FIELD_MASK =
      (DATA_W'({THR_W{1'b1}}) << SOFT_LSB) | (DATA_W'({THR_W{1'b1}}) << HARD_LSB);

  logic [THR_W-1:0]  field_val  [NFIELD];
  logic [DATA_W-1:0] field_word [NFIELD];

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    localparam int unsigned LSB = (f == 0) ? SOFT_LSB : HARD_LSB;
    logic [STORE_W-1:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      store_q <= '0;
      else if (cfg_we) store_q <= cfg_wdata[LSB+ALIGN +: STORE_W];
    end

    assign field_val[f]  = {store_q, {ALIGN{1'b0}}};
    assign field_word[f] = DATA_W'(field_val[f]) << LSB;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NFIELD; i++) cfg_rdata = cfg_rdata | field_word[i];
  end

  assign soft_thr = field_val[0];
  assign hard_thr = field_val[1];

  assert_wr_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == (drq_pkg::align_down($past(cfg_wdata), 0) & FIELD_MASK &
                             ~((DATA_W'({ALIGN{1'b1}}) << SOFT_LSB) |
                               (DATA_W'({ALIGN{1'b1}}) << HARD_LSB))));
  // R7: the soft reset does not disturb the configuration word
  assert_kept_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));
  assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~FIELD_MASK) == '0);
  assert_lsb_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[SOFT_LSB +: ALIGN] == '0 && cfg_rdata[HARD_LSB +: ALIGN] == '0);

  logic unused_soft;
  assign unused_soft = soft_rst;
endmodule

// File: rtl/drq_idle_det.sv
module drq_idle_det #(
  parameter int unsigned IDLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic bus_busy,
  output logic bus_idle
);
  localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
  localparam logic [7:0] LIMIT8 = 8'(IDLE_CYCLES);

  logic [CW-1:0] quiet_q;
  logic [7:0]    quiet_next;

  always_comb quiet_next = drq_pkg::idle_step(8'(quiet_q), bus_busy, LIMIT8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= '0;
    else if (soft_rst) quiet_q <= '0;
    else               quiet_q <= quiet_next[CW-1:0];
  end

  assign bus_idle = (quiet_q == CW'(IDLE_CYCLES));

  assert_busy_kills_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |=> !bus_idle);
  assert_idle_sticks_R3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    bus_idle && !bus_busy |=> bus_idle);
endmodule

// File: rtl/drq_req_ctrl.sv
module drq_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic hard_hit,
  input  logic soft_hit,
  input  logic res_ok,
  input  logic req_ack,
  output logic bus_req
);
  logic eligible;
  assign eligible = (hard_hit || soft_hit) && res_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_req <= 1'b0;
    else if (soft_rst)           bus_req <= 1'b0;
    else if (bus_req && req_ack) bus_req <= 1'b0;
    else if (!bus_req)           bus_req <= eligible;
  end

  assert_hard_now_R2: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !bus_req && hard_hit && res_ok |=> bus_req);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    bus_req && !req_ack |=> bus_req);
  assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && req_ack |=> !bus_req);
endmodule

// File: rtl/drain_req_sched.sv
module drain_req_sched #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned CNT_W       = 7,
  parameter int unsigned THR_W       = 6,
  parameter int unsigned ALIGN       = 2,
  parameter int unsigned SOFT_LSB    = 0,
  parameter int unsigned HARD_LSB    = 16,
  parameter int unsigned RES_W       = 4,
  parameter int unsigned IDLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              bus_busy,
  input  logic [RES_W-1:0]  res_count,
  input  logic              req_ack,
  output logic              bus_req
);
  logic [THR_W-1:0] soft_thr, hard_thr;
  logic bus_idle, hard_hit, soft_over, soft_hit, res_ok;

  drq_thr_reg #(
    .DATA_W(DATA_W), .THR_W(THR_W), .ALIGN(ALIGN),
    .SOFT_LSB(SOFT_LSB), .HARD_LSB(HARD_LSB)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .soft_thr(soft_thr), .hard_thr(hard_thr)
  );

  drq_idle_det #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .bus_busy(bus_busy), .bus_idle(bus_idle)
  );

  assign hard_hit  = drq_pkg::exceeds(32'(fifo_count), 32'(hard_thr));
  assign soft_over = drq_pkg::exceeds(32'(fifo_count), 32'(soft_thr));
  assign soft_hit  = soft_over && bus_idle;
  assign res_ok    = (res_count != '0);

  drq_req_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .hard_hit(hard_hit), .soft_hit(soft_hit), .res_ok(res_ok),
    .req_ack(req_ack), .bus_req(bus_req)
  );

  assert_strict_R1: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(bus_req) |-> $past(fifo_count > CNT_W'(hard_thr) || fifo_count > CNT_W'(soft_thr)));
  assert_no_res_R6: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(bus_req) |-> $past(res_count) != '0);
  assert_soft_needs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(bus_req) && !$past(hard_hit) |-> $past(bus_idle));
  // R9: a zero limit and an empty FIFO never give a request
  assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    $rose(bus_req) |-> $past(fifo_count) != '0);
endmodule

// File: tb/drain_req_sched_bench.sv
module drain_req_sched_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, soft_rst = 0, cfg_we = 0, bus_busy = 1, req_ack = 0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [6:0]  fifo_count = '0;
  logic [3:0]  res_count = 4'd1;
  logic        bus_req;
  int checks = 0, errors = 0;
  bit done = 0;
  int hard_l, soft_l;

  always #(CLK_PERIOD/2) clk = ~clk;

  drain_req_sched u_drain_req_sched (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fifo_count(fifo_count),
    .bus_busy(bus_busy), .res_count(res_count), .req_ack(req_ack), .bus_req(bus_req)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_we = 1; cfg_wdata = v;
    tick(1);
    cfg_we = 0;
  endtask

  function automatic logic [31:0] cfg_model(input logic [31:0] v);
    return (((v >> 16) & 32'h3C) << 16) | (v & 32'h3C);
  endfunction

  task automatic clear_req();
    fifo_count = 0; bus_busy = 1; req_ack = 1;
    tick(1);
    req_ack = 0;
    tick(1);
  endtask

  initial begin
    logic [31:0] cfgs [4];
    cfgs[0] = 32'h0010_0008; cfgs[1] = 32'h0000_0000;
    cfgs[2] = 32'h003C_0004; cfgs[3] = 32'h0008_0020;
    tick(2);
    rst_n = 1;
    tick(1);
    check("R7 reset cfg", cfg_rdata, 0);
    check("R7 reset req", {31'd0, bus_req}, 0);

    write_cfg(32'h0004_0002);
    check("R4 recommended value masked", cfg_rdata, 32'h0004_0000);
    write_cfg(32'hFFFF_FFFF);
    check("R5 reserved and R4 lsbs", cfg_rdata, 32'h003C_003C);
    write_cfg(32'h0024_0018);
    check("R10 field positions", cfg_rdata, 32'h0024_0018);

    for (int k = 0; k < 4; k++) begin
      write_cfg(cfgs[k]);
      check("R10 sweep cfg", cfg_rdata, cfg_model(cfgs[k]));
      hard_l = int'((cfgs[k] >> 16) & 32'h3C);
      soft_l = int'(cfgs[k] & 32'h3C);
      clear_req();
      for (int c = 0; c <= 66; c++) begin
        res_count = 4'd1;
        fifo_count = 7'(c); bus_busy = 1;
        tick(1);
        check((hard_l == 0) ? "R9 R2 busy hard" : "R1 R2 busy hard",
              {31'd0, bus_req}, {31'd0, c > hard_l});
        clear_req();
        fifo_count = 7'(c); bus_busy = 0;
        tick(5);
        check((soft_l == 0) ? "R9 R3 idle soft" : "R1 R3 idle soft",
              {31'd0, bus_req}, {31'd0, (c > hard_l) || (c > soft_l)});
        clear_req();
      end
    end

    write_cfg(32'h003C_0008);
    clear_req();
    fifo_count = 20; bus_busy = 0;
    tick(4);
    check("R3 not before fifth quiet edge", {31'd0, bus_req}, 0);
    tick(1);
    check("R3 at fifth quiet edge", {31'd0, bus_req}, 1);
    clear_req();
    fifo_count = 20; bus_busy = 0;
    tick(3);
    bus_busy = 1;
    tick(1);
    bus_busy = 0;
    tick(3);
    check("R3 busy restarts window", {31'd0, bus_req}, 0);
    tick(2);
    check("R3 after restart", {31'd0, bus_req}, 1);

    write_cfg(32'h0010_0008);
    clear_req();
    fifo_count = 40; bus_busy = 0; res_count = 0;
    tick(8);
    check("R6 no resources", {31'd0, bus_req}, 0);
    res_count = 3;
    tick(1);
    check("R6 resources return", {31'd0, bus_req}, 1);

    fifo_count = 0;
    tick(3);
    check("R8 hold without ack", {31'd0, bus_req}, 1);
    fifo_count = 40; req_ack = 1;
    tick(1);
    check("R8 drop on ack", {31'd0, bus_req}, 0);
    req_ack = 0;
    tick(1);
    check("R8 re-raise", {31'd0, bus_req}, 1);

    soft_rst = 1;
    tick(1);
    soft_rst = 0; fifo_count = 0;
    check("R7 soft reset keeps cfg", cfg_rdata, 32'h0010_0008);
    check("R7 soft reset clears req", {31'd0, bus_req}, 0);
    rst_n = 0;
    tick(1);
    rst_n = 1;
    tick(1);
    check("R7 chip reset clears cfg", cfg_rdata, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule